// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects interrupt events for a small 8-bit processor and decides which one, if any, the processor should service next. Five event sources feed single-cycle pulses into a pending-flag register. Software controls the block through byte-wide bus accesses: it sets which sources may interrupt through an enable register, and it can inspect, set or clear pending flags directly. A global master-enable bit gates the whole mechanism. The instruction decoder drives this bit through three strobes: one that enables, one that disables, and one for return-from-interrupt.

Whenever the master enable is on and at least one pending source is also enabled, the block raises a dispatch request. The request carries the handler address of the winning source, which is the lowest-numbered eligible source. The processor accepts the request at an instruction boundary by asserting the acknowledge. In that cycle the block clears the serviced flag and drops the master enable, so that a handler is not interrupted unless it re-enables interrupts itself. Pushing the program counter is the processor's job.

The request/acknowledge pair works like a valid/ready handshake carrying the vector. A transfer happens only in a cycle where both are high. The request is a level, not a promise: it may fall before any acknowledge if software clears the flag, masks the source or turns off the master enable. The vector may change while the request waits if a higher-priority source becomes pending. An acknowledge given while the request is low has no effect.

Top module: `irq_ctrl`

## Requirements
- R1: Source bits are numbered 0 vertical blank, 1 LCD status, 2 timer overflow, 3 serial complete, 4 joypad. A one-cycle pulse on `src_pulse[i]` sets pending flag i, and the flag is visible at the edge after the pulse.
- R2: A read at address 0xFF0F returns the five pending flags in bits 4..0, and bits 7..5 read as 1.
- R3: A write to 0xFF0F loads bits 4..0 into the pending flags, setting or clearing each one. If a source pulse and a write of 0 hit the same bit in the same cycle, the bit ends up set.
- R4: The enable register sits at 0xFFFF. Writes keep bits 4..0, and a read returns them with bits 7..5 as 0.
- R5: `irq_req` is high exactly when the master enable is set and the bitwise AND of enables and pending flags is non-zero.
- R6: While `irq_req` is high, `irq_vec` equals 0x0040 + 8 × (index of the lowest set bit of enables AND flags).
- R7: In a cycle where `irq_req` and `irq_ack` are both high, the serviced flag is cleared and the master enable is turned off, effective at that edge. Other flags keep their values, and a source pulse on the serviced bit in that same cycle keeps it set.
- R8: `irq_ack` while `irq_req` is low changes neither the flags nor the master enable.
- R9: `op_ei` and `op_reti` set the master enable and `op_di` clears it, effective at the next edge. When strobes collide, a dispatch clears it first, then `op_di` wins over `op_ei`/`op_reti`.
- R10: After reset the flags, enables and master enable are all 0, so `irq_req` is low and 0xFF0F reads 0xE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 5 | One-cycle event pulses, bit i = source i |
| bus_addr | input | 16 | Bus address for reads and writes |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| op_ei | input | 1 | Decoded enable-interrupts strobe |
| op_di | input | 1 | Decoded disable-interrupts strobe |
| op_reti | input | 1 | Decoded return-from-interrupt strobe |
| irq_req | output | 1 | Dispatch request (valid) |
| irq_ack | input | 1 | Dispatch accept (ready) at an instruction boundary |
| irq_vec | output | 16 | Handler address of the winning source |

## Verification
A corrupted pending flag can be seen in the next cycle through a read of 0xFF0F. Once the source is enabled and the master enable is on, it also shows as a wrong `irq_vec`. A master enable stuck in the wrong state shows only indirectly, as `irq_req` being high or low against the rule of R5. It is visible the cycle after the strobe or handshake that should have moved it. The bench therefore always checks the master enable through the request, with the flags and enables set to known values. It checks each priority slot by walking the lowest set bit from 0 to 4 and reading the vector.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;

  typedef enum logic [2:0] {
    SRC_VBLANK = 3'd0,
    SRC_LCDSTAT = 3'd1,
    SRC_TIMER  = 3'd2,
    SRC_SERIAL = 3'd3,
    SRC_JOYPAD = 3'd4
  } irq_src_e;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pulse,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] base, nxt;

  always_comb begin
    base = load ? load_val : flags;
    nxt  = (base & ~clr) | pulse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  // R1: every pulsed source bit is pending after the edge
  p_pulse_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |=> ((flags & $past(pulse)) == $past(pulse)));

  // R7: serviced bit cleared when no new pulse on it
  p_clr_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr) && ((clr & pulse) == '0)) |=> ((flags & $past(clr)) == '0));

  // R7: at most one bit is serviced per handshake
  p_clr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     cand,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | cand[i];
    assign grant[i]  = cand[i] & ~seen[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_master.sv
module irq_master (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  input  logic take,
  output logic ime
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ime <= 1'b0;
    else if (take)   ime <= 1'b0;
    else if (clr_en) ime <= 1'b0;
    else if (set_en) ime <= 1'b1;
  end

  // R7: a dispatch always leaves the master enable off
  p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ime);

  // R9: enable strobe without a competing clear sets it
  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en && !take) |=> ime);

  // R9: disable strobe wins
  p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !ime);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned          NSRC       = NUM_SRC,
  parameter int unsigned          AW         = ADDR_W,
  parameter int unsigned          DW         = DATA_W,
  parameter logic [ADDR_W-1:0]    FLAG_ADDR  = 16'hFF0F,
  parameter logic [ADDR_W-1:0]    EN_ADDR    = 16'hFFFF,
  parameter logic [ADDR_W-1:0]    VEC_BASE   = 16'h0040,
  parameter int unsigned          VEC_STRIDE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            op_ei,
  input  logic            op_di,
  input  logic            op_reti,
  output logic            irq_req,
  input  logic            irq_ack,
  output logic [AW-1:0]   irq_vec
);
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int unsigned PAD_W = DW - NSRC;
  localparam logic [AW-1:0] VEC_LAST = VEC_BASE + AW'((NSRC - 1) * VEC_STRIDE);

  logic [NSRC-1:0]  en_q, flags, cand, grant;
  logic [IDX_W-1:0] win_idx;
  logic             win_any, ime, take;
  logic             hit_flag, hit_en;

  assign hit_flag = (bus_addr == FLAG_ADDR);
  assign hit_en   = (bus_addr == EN_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)                en_q <= '0;
    else if (bus_wr && hit_en) en_q <= bus_wdata[NSRC-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_flag)    bus_rdata = {{PAD_W{1'b1}}, flags};
    else if (hit_en) bus_rdata = {{PAD_W{1'b0}}, en_q};
  end

  assign cand    = en_q & flags;
  assign irq_req = ime & win_any;
  assign take    = irq_req & irq_ack;
  assign irq_vec = VEC_BASE + AW'(win_idx) * AW'(VEC_STRIDE);

  irq_pending #(.N(NSRC)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse    (src_pulse),
    .load     (bus_wr & hit_flag),
    .load_val (bus_wdata[NSRC-1:0]),
    .clr      (take ? grant : '0),
    .flags    (flags)
  );

  irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .cand  (cand),
    .grant (grant),
    .idx   (win_idx),
    .any   (win_any)
  );

  irq_master u_master (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (op_ei | op_reti),
    .clr_en (op_di),
    .take   (take),
    .ime    (ime)
  );

  // R6: vector inside the table and on a slot boundary
  p_vec_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((irq_vec >= VEC_BASE) && (irq_vec <= VEC_LAST) &&
                 (((irq_vec - VEC_BASE) % AW'(VEC_STRIDE)) == '0)));

  // R7: request withdrawn after a handshake
  p_req_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);

  // R8: ack without request leaves flags alone
  p_ack_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !bus_wr && (src_pulse == '0)) |=> $stable(flags));
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  src_pulse;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        op_ei, op_di, op_reti;
  logic        irq_req, irq_ack;
  logic [15:0] irq_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .op_ei(op_ei), .op_di(op_di), .op_reti(op_reti),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic strobe(input bit ei, input bit di, input bit reti);
    op_ei = ei; op_di = di; op_reti = reti;
    tick();
    op_ei = 1'b0; op_di = 1'b0; op_reti = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(16'hFF0F, d); chk("R10 flags after reset", 16'(d), 16'h00E0);
    rd(16'hFFFF, d); chk("R10 enables after reset", 16'(d), 16'h0000);
    chk("R10 req after reset", 16'(irq_req), 16'h0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(16'hFFFF, 8'hFF);
    rd(16'hFFFF, d); chk("R4 enable keeps low five", 16'(d), 16'h001F);
    wr(16'hFFFF, 8'h00);
    wr(16'hFF0F, 8'h15);
    rd(16'hFF0F, d); chk("R2 R3 flag write 15", 16'(d), 16'h00F5);
    wr(16'hFF0F, 8'h0A);
    rd(16'hFF0F, d); chk("R3 flag write 0A", 16'(d), 16'h00EA);
    wr(16'hFF0F, 8'h00);
    rd(16'hFF0F, d); chk("R3 flag clear", 16'(d), 16'h00E0);
  endtask

  task automatic t_pulses();
    logic [7:0] d;
    for (int i = 0; i < 5; i++) begin
      src_pulse = 5'(1 << i);
      tick();
      src_pulse = '0;
      rd(16'hFF0F, d); chk($sformatf("R1 pulse src %0d", i), 16'(d), 16'(8'hE0 | (1 << i)));
      wr(16'hFF0F, 8'h00);
    end
    // pulse and write of 0 on the same bit: pulse wins
    bus_addr = 16'hFF0F; bus_wdata = 8'h00; bus_wr = 1'b1; src_pulse = 5'b00010;
    tick();
    bus_wr = 1'b0; src_pulse = '0;
    rd(16'hFF0F, d); chk("R3 pulse beats write zero", 16'(d), 16'h00E2);
    wr(16'hFF0F, 8'h00);
  endtask

  task automatic t_req_and_prio();
    wr(16'hFFFF, 8'h1F);
    wr(16'hFF0F, 8'h04);
    chk("R5 no req with master off", 16'(irq_req), 16'h0);
    strobe(1, 0, 0);
    chk("R9 R5 EI raises req", 16'(irq_req), 16'h1);
    chk("R6 vector timer", irq_vec, 16'h0050);
    wr(16'hFF0F, 8'h1F); chk("R6 vector lowest 0", irq_vec, 16'h0040);
    wr(16'hFF0F, 8'h1E); chk("R6 vector lowest 1", irq_vec, 16'h0048);
    wr(16'hFF0F, 8'h18); chk("R6 vector lowest 3", irq_vec, 16'h0058);
    wr(16'hFF0F, 8'h10); chk("R6 vector lowest 4", irq_vec, 16'h0060);
    wr(16'hFFFF, 8'h1E);
    wr(16'hFF0F, 8'h03); chk("R6 masked bit 0 skipped", irq_vec, 16'h0048);
    wr(16'hFFFF, 8'h0C);
    wr(16'hFF0F, 8'h13); chk("R5 enabled AND empty", 16'(irq_req), 16'h0);
    wr(16'hFFFF, 8'h1F);
  endtask

  task automatic t_dispatch();
    logic [7:0] d;
    wr(16'hFF0F, 8'h0A);
    chk("R6 vector before ack", irq_vec, 16'h0048);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    rd(16'hFF0F, d); chk("R7 serviced flag cleared", 16'(d), 16'h00E8);
    chk("R7 master off after dispatch", 16'(irq_req), 16'h0);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    rd(16'hFF0F, d); chk("R8 ack without req ignored", 16'(d), 16'h00E8);
    chk("R8 master stays off", 16'(irq_req), 16'h0);
    strobe(1, 0, 0);
    chk("R9 nested EI re-raises", 16'(irq_req), 16'h1);
    chk("R6 next vector serial", irq_vec, 16'h0058);
    // pulse on serviced bit during handshake keeps it pending
    irq_ack = 1'b1; src_pulse = 5'b01000;
    tick();
    irq_ack = 1'b0; src_pulse = '0;
    rd(16'hFF0F, d); chk("R7 pulse during ack keeps bit", 16'(d), 16'h00E8);
    wr(16'hFF0F, 8'h01);
  endtask

  task automatic t_strobes();
    strobe(0, 0, 1);
    chk("R9 RETI sets master", 16'(irq_req), 16'h1);
    strobe(0, 1, 0);
    chk("R9 DI clears master", 16'(irq_req), 16'h0);
    strobe(1, 1, 0);
    chk("R9 DI beats EI", 16'(irq_req), 16'h0);
    strobe(1, 0, 0);
    chk("R9 EI again", 16'(irq_req), 16'h1);
    op_ei = 1'b1; irq_ack = 1'b1;
    tick();
    op_ei = 1'b0; irq_ack = 1'b0;
    wr(16'hFF0F, 8'h01);
    chk("R9 dispatch beats EI", 16'(irq_req), 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; src_pulse = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    op_ei = 1'b0; op_di = 1'b0; op_reti = 1'b0; irq_ack = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_regs();
    t_pulses();
    t_req_and_prio();
    t_dispatch();
    t_strobes();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule